// File: doc/BRIEF.md
# Backlash Phase-Frequency Detector

This block compares two pulse streams in the digital domain: a reference pulse and a feedback divider pulse. It drives two charge-pump steering lines, `pumpUp` and `pumpDown`. A rising edge on the reference asserts `pumpUp` and a rising edge on the divider asserts `pumpDown`. Whichever line rises first stays high for longer, so the difference in width between the two pulses carries the phase and frequency error to the pump.

A charge pump cannot switch its current sources on and off in zero time, which leaves a dead zone at very small phase errors. To close that dead zone, the block keeps both lines high together for a programmable number of sampling-clock cycles, called the backlash hold, in every comparison cycle. It does this even when the phase error is zero. Edges that arrive while a hold is running are kept and handled as soon as the hold ends. The block also forwards a 2-bit pump-current code through one register stage so that the code changes in step with the steering outputs.

Top module: `pfd_backlash`

## Requirements
- R1: A rising edge of `refPulse` (high in a cycle after low in the previous cycle) sets `pumpUp` at the next clock edge. A level that stays high does not trigger again.
- R2: A rising edge of `divPulse` sets `pumpDown` at the next clock edge.
- R3: Once both lines are set, they stay high together for exactly `holdCycles` clock cycles and then clear at the same edge. The line that rose first is therefore wider by the number of cycles between the two edges.
- R4: When both edges arrive in the same cycle (zero phase error), `pumpUp` and `pumpDown` are pulses of equal width, each `holdCycles` wide.
- R5: A `holdCycles` value of 0 behaves as a value of 1.
- R6: An edge on either input that arrives while a hold is running is stored. This includes an edge in the cycle where the hold clears. The stored edge sets its line one clock after the clear.
- R7: A further edge on an input whose line is already set, outside a hold, has no effect.
- R8: `pumpCur` equals the `pumpCode` value from one clock earlier, and it is 0 during reset.
- R9: Active-low reset `rstN` drives `pumpUp` and `pumpDown` low and discards any running hold and any stored edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refPulse | input | 1 | Reference divider pulse |
| divPulse | input | 1 | Feedback divider pulse |
| holdCycles | input | HOLD_W | Backlash hold length in clock cycles |
| pumpCode | input | 2 | Pump current magnitude code |
| pumpUp | output | 1 | Charge-pump up steering line |
| pumpDown | output | 1 | Charge-pump down steering line |
| pumpCur | output | 2 | Registered pump current code |

## Verification
The two functions that can fall in the same cycle are the end of a backlash hold and the arrival of a new input edge. If an edge lands on the clearing cycle, it could be lost or it could wrongly keep the line high. The bench places a reference edge exactly on the clearing cycle and another edge several cycles inside the hold. In both cases it requires the line to read low for one sample after the clear and high on the next sample, and it requires the total pulse widths to match the count computed from the hold length.

// File: rtl/pfd_bl_pkg.sv
package pfd_bl_pkg;
  typedef struct packed {
    logic loadCnt;   // start a backlash hold
    logic decCnt;    // count the hold down
    logic capture;   // hold running: store edges for later
  } pfdStrobe_t;
endpackage

// File: rtl/pfd_bl_datapath.sv
module pfd_bl_datapath
  import pfd_bl_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refPulse,
  input  logic              divPulse,
  input  logic [HOLD_W-1:0] holdCycles,
  input  pfdStrobe_t        st,
  output logic              refHit,
  output logic              divHit,
  output logic              cntLast
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic refPrev, divPrev, refPend, divPend;
  logic refEdge, divEdge;
  logic [HOLD_W-1:0] cnt;

  assign refEdge = refPulse & ~refPrev;
  assign divEdge = divPulse & ~divPrev;
  assign refHit  = refEdge | refPend;
  assign divHit  = divEdge | divPend;
  assign cntLast = (cnt == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      divPrev <= 1'b0;
      refPend <= 1'b0;
      divPend <= 1'b0;
      cnt     <= '0;
    end else begin
      refPrev <= refPulse;
      divPrev <= divPulse;
      if (st.capture) begin
        refPend <= refPend | refEdge;
        divPend <= divPend | divEdge;
      end else begin
        refPend <= 1'b0;
        divPend <= 1'b0;
      end
      if (st.loadCnt)
        cnt <= (holdCycles == '0) ? ONE : holdCycles;
      else if (st.decCnt)
        cnt <= cnt - ONE;
    end
  end

  // R5
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |-> cnt != '0);
  // R6
  pend_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.capture && refEdge) |=> refPend);
endmodule

// File: rtl/pfd_bl_control.sv
module pfd_bl_control
  import pfd_bl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       refHit,
  input  logic       divHit,
  input  logic       cntLast,
  output pfdStrobe_t st,
  output logic       pumpUp,
  output logic       pumpDown
);
  logic upQ, dnQ, holdQ;
  logic upNext, dnNext;

  assign upNext = upQ | refHit;
  assign dnNext = dnQ | divHit;

  always_comb begin
    st.capture = holdQ;
    st.loadCnt = !holdQ && upNext && dnNext;
    st.decCnt  = holdQ && !cntLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ   <= 1'b0;
      dnQ   <= 1'b0;
      holdQ <= 1'b0;
    end else if (holdQ) begin
      if (cntLast) begin
        upQ   <= 1'b0;
        dnQ   <= 1'b0;
        holdQ <= 1'b0;
      end
    end else begin
      upQ   <= upNext;
      dnQ   <= dnNext;
      holdQ <= upNext && dnNext;
    end
  end

  assign pumpUp   = upQ;
  assign pumpDown = dnQ;

  // R3
  hold_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdQ |-> (pumpUp && pumpDown));
  // R3
  clear_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pumpUp) |-> $fell(pumpDown));
endmodule

// File: rtl/pfd_backlash.sv
module pfd_backlash
  import pfd_bl_pkg::*;
#(
  parameter int HOLD_W = 8,
  parameter int CUR_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refPulse,
  input  logic              divPulse,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic [CUR_W-1:0]  pumpCode,
  output logic              pumpUp,
  output logic              pumpDown,
  output logic [CUR_W-1:0]  pumpCur
);
  pfdStrobe_t st;
  logic refHit, divHit, cntLast;

  pfd_bl_datapath #(.HOLD_W(HOLD_W)) dp (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .divPulse(divPulse),
    .holdCycles(holdCycles), .st(st), .refHit(refHit), .divHit(divHit),
    .cntLast(cntLast)
  );

  pfd_bl_control ctl (
    .clk(clk), .rstN(rstN), .refHit(refHit), .divHit(divHit),
    .cntLast(cntLast), .st(st), .pumpUp(pumpUp), .pumpDown(pumpDown)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pumpCur <= '0;
    else       pumpCur <= pumpCode;
  end

  // R8
  cur_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> pumpCur == $past(pumpCode));
endmodule

// File: tb/pfd_backlash_test.sv
`timescale 1ns/1ps
module pfd_backlash_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refPulse = 1'b0, divPulse = 1'b0;
  logic [7:0] holdCycles = 8'd4;
  logic [1:0] pumpCode = 2'd3;
  logic pumpUp, pumpDown;
  logic [1:0] pumpCur;
  int nRun = 0, nFail = 0;
  logic [63:0] upTr, dnTr;

  always #4 clk = ~clk;

  pfd_backlash uut (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .divPulse(divPulse),
    .holdCycles(holdCycles), .pumpCode(pumpCode), .pumpUp(pumpUp),
    .pumpDown(pumpDown), .pumpCur(pumpCur)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drives one comparison scenario and records pumpUp/pumpDown per cycle.
  task automatic runTrace(input int refAt, input int refLen, input int refAt2,
                          input int divAt, input int divAt2, input int hold);
    holdCycles = 8'(hold);
    upTr = '0; dnTr = '0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (i < 64) begin
        upTr[i] = pumpUp;
        dnTr[i] = pumpDown;
      end
      refPulse = (i >= refAt && i < refAt + refLen) || i == refAt2;
      divPulse = (i == divAt) || i == divAt2;
    end
    refPulse = 1'b0; divPulse = 1'b0;
  endtask

  task automatic checkWidths(input string req, input int eUp, input int eDn,
                             input int eBoth);
    chk($countones(upTr) == eUp, req, "up width", $countones(upTr), eUp);
    chk($countones(dnTr) == eDn, req, "down width", $countones(dnTr), eDn);
    chk($countones(upTr & dnTr) == eBoth, req, "overlap",
        $countones(upTr & dnTr), eBoth);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!pumpUp && !pumpDown, "R9", "outputs in reset", int'(pumpUp | pumpDown), 0);
    chk(pumpCur == 2'd0, "R8", "current code in reset", pumpCur, 0);
    rstN = 1'b1;
  endtask

  task automatic testZeroError();
    runTrace(0, 1, -1, 0, -1, 5);   // R4
    checkWidths("R4", 5, 5, 5);
    chk(upTr[1] && dnTr[1] && !upTr[0], "R1", "up rises one clock after edge",
        int'(upTr[1]), 1);
  endtask

  task automatic testRefLead();
    runTrace(0, 1, -1, 3, -1, 4);   // R3
    checkWidths("R3", 7, 4, 4);
    chk(!dnTr[3] && dnTr[4], "R2", "down rises one clock after edge",
        int'(dnTr[4]), 1);
  endtask

  task automatic testDivLead();
    runTrace(2, 1, -1, 0, -1, 3);
    checkWidths("R3", 3, 5, 3);
  endtask

  task automatic testZeroHold();
    runTrace(0, 1, -1, 0, -1, 0);   // R5
    checkWidths("R5", 1, 1, 1);
  endtask

  task automatic testLevel();
    runTrace(0, 10, -1, 4, -1, 2);  // R1: held level counts once
    checkWidths("R1", 6, 2, 2);
  endtask

  task automatic testPendMid();
    runTrace(0, 1, 3, 0, 20, 6);    // R6
    checkWidths("R6", 25, 12, 12);
    chk(!upTr[7] && upTr[8], "R6", "stored ref edge applied after clear",
        int'(upTr[8]), 1);
  endtask

  task automatic testPendOnClear();
    runTrace(0, 1, 6, 0, 20, 6);    // R6: edge on the clearing cycle
    chk(!upTr[7], "R6", "up low right after clear", int'(upTr[7]), 0);
    chk(upTr[8], "R6", "edge on clear cycle kept", int'(upTr[8]), 1);
    checkWidths("R6", 25, 12, 12);
  endtask

  task automatic testPendDiv();
    runTrace(0, 1, 15, 0, 3, 4);    // R6 on the divider side
    checkWidths("R6", 8, 18, 8);
  endtask

  task automatic testRepeat();
    runTrace(0, 1, 5, 12, -1, 2);   // R7
    checkWidths("R7", 14, 2, 2);
  endtask

  task automatic testCurrent();
    @(negedge clk); pumpCode = 2'd2;
    @(negedge clk);
    chk(pumpCur == 2'd2, "R8", "code forwarded", pumpCur, 2);
    pumpCode = 2'd1;
    chk(pumpCur == 2'd2, "R8", "code held until edge", pumpCur, 2);
    @(negedge clk);
    chk(pumpCur == 2'd1, "R8", "code updated", pumpCur, 1);
  endtask

  task automatic testMidReset();
    holdCycles = 8'd10;
    @(negedge clk); refPulse = 1'b1; divPulse = 1'b1;
    @(negedge clk); refPulse = 1'b0; divPulse = 1'b0;
    @(negedge clk); @(negedge clk); refPulse = 1'b1;
    @(negedge clk); refPulse = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk(!pumpUp && !pumpDown, "R9", "outputs cleared mid hold",
        int'(pumpUp | pumpDown), 0);
    rstN = 1'b1;
    runTrace(-5, 0, -1, -5, -1, 10); // no stimulus: stored edge must be gone
    checkWidths("R9", 0, 0, 0);
    runTrace(0, 1, -1, 0, -1, 3);
    checkWidths("R9", 3, 3, 3);
  endtask

  bit done = 0;
  initial begin
    testReset();
    testZeroError();
    testRefLead();
    testDivLead();
    testZeroHold();
    testLevel();
    testPendMid();
    testPendOnClear();
    testPendDiv();
    testRepeat();
    testCurrent();
    testMidReset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule